// File: doc/BRIEF.md
# Dual-Clock Cell Buffer

This block moves fixed-format cells from a fast write clock domain to a slower read clock domain. The writer presents 33-bit words with no handshake. Bit 32 of each word flags the first word of a cell. A separate input tags words that belong to idle fill cells, which the logic generates on its own. Each stored entry is 34 bits wide: the idle tag, the start flag and 32 payload bits. The default store holds 64 entries, which is enough for two maximum-length cells of 23 words plus margin. One cell is being written while another is being read.

Pointers cross between the two domains as gray codes through two-flop synchronizers. A count of closed cells crosses the same way. A cell closes when its 23rd word is written, or when the next start-of-cell word arrives, whichever comes first. The read side does not begin a cell until that cell has closed, so the downstream frame assembler never stalls inside a cell. Read data is registered. Overflow and underrun cannot happen in correct use. If either occurs anyway, the offending access is dropped and a sticky error bit is set.

Top module: `cell_fifo`

## Requirements
- R1: After reset, rd_valid, rd_ready, wr_full, wr_err and rd_err are 0, and wr_level and rd_cells are 0.
- R2: Words come out in write order, each as {idle tag at bit 33, start flag at bit 32, payload at bits 31:0}, where the start flag is input bit 32 and the idle tag is wr_idle.
- R3: A read accepted on a rd_clk edge (rd_en high while rd_ready is high) gives rd_valid high with the word for exactly the next cycle. rd_word holds its value when no read is accepted.
- R4: A cell closes when it reaches MAX_CELL words (23 by default) or when the next start-of-cell word is written. rd_cells reports the closed cells whose first word has not yet been read.
- R5: rd_ready is low while the next stored word is a start-of-cell word and rd_cells is 0. A partly written cell therefore cannot be started. A word that has no start flag and belongs to no open cell is readable as soon as it is stored.
- R6: wr_level gives the number of stored words as seen from the write side, counting reads only after synchronization. wr_full is high when wr_level equals DEPTH (64).
- R7: A write while wr_full is high stores nothing and sets wr_err. wr_err stays set until write reset.
- R8: A read while rd_ready is low produces no rd_valid and sets rd_err. rd_err stays set until read reset.
- R9: wr_rst clears the write pointer, wr_level and wr_err. rd_rst clears the read pointer, rd_valid and rd_err. Both resets are synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 33 | Bit 32 start-of-cell flag, bits 31:0 payload |
| wr_idle | input | 1 | Tags the word as part of an idle fill cell |
| wr_full | output | 1 | Store holds DEPTH words |
| wr_level | output | 7 | Write-side occupancy |
| wr_err | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_ready | output | 1 | A word may be read this cycle |
| rd_valid | output | 1 | rd_word carries a fresh word |
| rd_word | output | 34 | Bit 33 idle tag, bit 32 start flag, bits 31:0 payload |
| rd_cells | output | 7 | Closed cells not yet started by the reader |
| rd_err | output | 1 | Sticky underrun flag |

## Verification
The checker watches several behaviours on every cycle: the one-cycle read latency and the holding of rd_word, dropped writes and reads with their sticky error bits, the bounds on occupancy and cell count, and the reset values. Other behaviours need the bench's scenarios. These are the order and field content of the data, cell closing by length or by the next start word, the refusal to start a partial cell, and the exact occupancy at full. The bench holds cells open, closes them each way, streams cells while reading, overfills the store and drains it.

// File: rtl/cellfifo_pkg.sv
package cellfifo_pkg;

    localparam int PAYLOAD_W = 32;
    localparam int IN_W      = PAYLOAD_W + 1;
    localparam int WORD_W    = PAYLOAD_W + 2;

    typedef struct packed {
        logic                 idle;
        logic                 soc;
        logic [PAYLOAD_W-1:0] data;
    } cell_word_t;

    function automatic cell_word_t pack_word(input logic [IN_W-1:0] w, input logic idle);
        cell_word_t r;
        r.idle = idle;
        r.soc  = w[IN_W-1];
        r.data = w[PAYLOAD_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/cellfifo_gray_sync.sv
module cellfifo_gray_sync #(
    parameter int W = 7
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] src_gray;
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    // one-bit-change code registered in the source domain
    always_ff @(posedge src_clk) begin
        if (src_rst) src_gray <= '0;
        else         src_gray <= src_bin ^ (src_bin >> 1);
    end

    // two-flop capture in the destination domain
    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= src_gray;
            safe_q <= meta_q;
        end
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ safe_q[i];
            dst_bin[i] = acc;
        end
    end
endmodule

// File: rtl/cellfifo_store.sv
module cellfifo_store #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6,
    parameter int WORD_W = 34
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] slots [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/cellfifo_wr_ctrl.sv
module cellfifo_wr_ctrl #(
    parameter int DEPTH    = 64,
    parameter int PTR_W    = 7,
    parameter int CNT_W    = 7,
    parameter int MAX_CELL = 23
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic             wr_soc,
    input  logic [PTR_W-1:0] rd_ptr_seen,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             mem_we,
    output logic             wr_full,
    output logic [PTR_W-1:0] wr_level,
    output logic             wr_err,
    output logic [CNT_W-1:0] closed_cnt
);
    localparam int LEN_W = $clog2(MAX_CELL + 1);

    logic             open_q;
    logic [LEN_W-1:0] len_q;
    logic             close_q;
    logic             accept;
    logic [LEN_W-1:0] len_n;
    logic             at_max;
    logic             close_now;

    assign wr_level = wr_ptr - rd_ptr_seen;
    assign wr_full  = (wr_level == PTR_W'(DEPTH));
    assign accept   = wr_en && !wr_full;
    assign mem_we   = accept;

    always_comb begin
        len_n     = wr_soc ? LEN_W'(1) : len_q + 1'b1;
        at_max    = (len_n == LEN_W'(MAX_CELL));
        close_now = accept && ((wr_soc && open_q) || ((wr_soc || open_q) && at_max));
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_ptr     <= '0;
            wr_err     <= 1'b0;
            open_q     <= 1'b0;
            len_q      <= '0;
            close_q    <= 1'b0;
            closed_cnt <= '0;
        end else begin
            wr_ptr     <= wr_ptr + PTR_W'(accept);
            wr_err     <= wr_err | (wr_en && wr_full);
            // delayed a cycle so the count never leads the words it covers
            close_q    <= close_now;
            closed_cnt <= closed_cnt + CNT_W'(close_q);
            if (accept && (wr_soc || open_q)) begin
                len_q  <= len_n;
                open_q <= !at_max;
            end
        end
    end
endmodule

// File: rtl/cellfifo_rd_ctrl.sv
module cellfifo_rd_ctrl
    import cellfifo_pkg::*;
#(
    parameter int PTR_W = 7,
    parameter int CNT_W = 7
) (
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] wr_ptr_seen,
    input  logic [CNT_W-1:0] closed_seen,
    input  cell_word_t       head,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             rd_ready,
    output logic             rd_valid,
    output cell_word_t       rd_word,
    output logic [CNT_W-1:0] rd_cells,
    output logic             rd_err
);
    logic [CNT_W-1:0] started_q;
    logic             have_word;
    logic             accept;

    assign have_word = (wr_ptr_seen != rd_ptr);
    assign rd_cells  = closed_seen - started_q;
    assign rd_ready  = have_word && (!head.soc || (rd_cells != '0));
    assign accept    = rd_en && rd_ready;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_ptr    <= '0;
            rd_valid  <= 1'b0;
            rd_word   <= '0;
            started_q <= '0;
            rd_err    <= 1'b0;
        end else begin
            rd_valid <= accept;
            rd_err   <= rd_err | (rd_en && !rd_ready);
            if (accept) begin
                rd_word   <= head;
                rd_ptr    <= rd_ptr + 1'b1;
                started_q <= started_q + CNT_W'(head.soc);
            end
        end
    end
endmodule

// File: rtl/cell_fifo.sv
module cell_fifo
    import cellfifo_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_CELL = 23,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int PTR_W   = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [IN_W-1:0]   wr_word,
    input  logic              wr_idle,
    output logic              wr_full,
    output logic [PTR_W-1:0]  wr_level,
    output logic              wr_err,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic [PTR_W-1:0]  rd_cells,
    output logic              rd_err
);
    cell_word_t       in_word;
    cell_word_t       head_word;
    cell_word_t       out_word;
    logic [PTR_W-1:0] wr_ptr_bin;
    logic [PTR_W-1:0] rd_ptr_bin;
    logic [PTR_W-1:0] wr_ptr_rdside;
    logic [PTR_W-1:0] rd_ptr_wrside;
    logic [PTR_W-1:0] closed_wrside;
    logic [PTR_W-1:0] closed_rdside;
    logic             store_we;

    assign in_word = pack_word(wr_word, wr_idle);
    assign rd_word = out_word;

    cellfifo_wr_ctrl #(
        .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(PTR_W), .MAX_CELL(MAX_CELL)
    ) u_wr (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_soc(in_word.soc),
        .rd_ptr_seen(rd_ptr_wrside), .wr_ptr(wr_ptr_bin), .mem_we(store_we),
        .wr_full(wr_full), .wr_level(wr_level), .wr_err(wr_err),
        .closed_cnt(closed_wrside)
    );

    cellfifo_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
    ) u_store (
        .wr_clk(wr_clk), .we(store_we), .waddr(wr_ptr_bin[ADDR_W-1:0]),
        .wdata(in_word), .raddr(rd_ptr_bin[ADDR_W-1:0]), .rdata(head_word)
    );

    cellfifo_gray_sync #(.W(PTR_W)) u_wptr_xing (
        .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_ptr_bin),
        .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(wr_ptr_rdside)
    );

    cellfifo_gray_sync #(.W(PTR_W)) u_rptr_xing (
        .src_clk(rd_clk), .src_rst(rd_rst), .src_bin(rd_ptr_bin),
        .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_bin(rd_ptr_wrside)
    );

    cellfifo_gray_sync #(.W(PTR_W)) u_cells_xing (
        .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(closed_wrside),
        .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(closed_rdside)
    );

    cellfifo_rd_ctrl #(.PTR_W(PTR_W), .CNT_W(PTR_W)) u_rd (
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .wr_ptr_seen(wr_ptr_rdside), .closed_seen(closed_rdside), .head(head_word),
        .rd_ptr(rd_ptr_bin), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_word(out_word), .rd_cells(rd_cells), .rd_err(rd_err)
    );
endmodule

// File: rtl/cell_fifo_checker.sv
module cell_fifo_checker #(
    parameter int DEPTH  = 64,
    parameter int PTR_W  = 7,
    parameter int WORD_W = 34
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en,
    input logic              wr_full,
    input logic [PTR_W-1:0]  wr_level,
    input logic              wr_err,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_word,
    input logic [PTR_W-1:0]  rd_cells,
    input logic              rd_err
);
    a_r3_valid_follows: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_ready) |=> rd_valid);

    a_r3_word_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_en && rd_ready) |=> (!rd_valid && $stable(rd_word)));

    a_r4_cells_bound: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_cells <= PTR_W'(DEPTH));

    a_r6_level_bound: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_level <= PTR_W'(DEPTH));

    a_r7_drop_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> (wr_err && $stable(wr_ptr)));

    a_r7_err_sticky: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_err |=> wr_err);

    a_r8_underrun: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_ready) |=> (!rd_valid && rd_err));

    a_r8_err_sticky: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_err |=> rd_err);

    a_r9_wr_reset: assert property (@(posedge wr_clk)
        wr_rst |=> (!wr_err && wr_level == '0 && wr_ptr == '0));

    a_r9_rd_reset: assert property (@(posedge rd_clk)
        rd_rst |=> (!rd_valid && !rd_err));
endmodule

bind cell_fifo cell_fifo_checker #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .WORD_W(cellfifo_pkg::WORD_W)
) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_full(wr_full),
    .wr_level(wr_level), .wr_err(wr_err), .wr_ptr(wr_ptr_bin),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_cells(rd_cells), .rd_err(rd_err)
);

// File: tb/cell_fifo_test.sv
`timescale 1ns/1ps
module cell_fifo_test;
    localparam real WR_PERIOD = 6.4;
    localparam real RD_PERIOD = 12.86;
    localparam int  DEPTH     = 64;
    localparam int  MAX_CELL  = 23;
    localparam int  PTR_W     = 7;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst = 1'b1;
    logic              rd_rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [32:0]       wr_word = '0;
    logic              wr_idle = 1'b0;
    logic              wr_full;
    logic [PTR_W-1:0]  wr_level;
    logic              wr_err;
    logic              rd_en = 1'b0;
    logic              rd_ready;
    logic              rd_valid;
    logic [33:0]       rd_word;
    logic [PTR_W-1:0]  rd_cells;
    logic              rd_err;

    int          checks = 0;
    int          errors = 0;
    logic [33:0] exp_q[$];
    bit          rd_go = 1'b0;
    bit          force_rd = 1'b0;
    bit          pend = 1'b0;
    int unsigned seq = 0;

    always #(WR_PERIOD / 2.0) wr_clk = ~wr_clk;
    always #(RD_PERIOD / 2.0) rd_clk = ~rd_clk;

    cell_fifo #(.DEPTH(DEPTH), .MAX_CELL(MAX_CELL)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_word(wr_word),
        .wr_idle(wr_idle), .wr_full(wr_full), .wr_level(wr_level), .wr_err(wr_err),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_word(rd_word), .rd_cells(rd_cells), .rd_err(rd_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // driver: one word per write clock, expected word queued when it will be stored
    task automatic put_word(input bit soc, input bit idle, input bit keep);
        wr_en   = 1'b1;
        wr_word = {soc, seq ^ 32'hC3A50000};
        wr_idle = idle;
        if (keep) exp_q.push_back({idle, soc, seq ^ 32'hC3A50000});
        seq++;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic put_cell(input int len, input bit idle);
        for (int i = 0; i < len; i++) put_word(i == 0, idle, 1'b1);
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // reader and monitor share the read clock's falling edge
    always @(negedge rd_clk) begin
        if (pend) check(rd_valid == 1'b1, "R3 valid after accepted read", 64'(rd_valid), 64'd1);
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected word", 64'(rd_word), 64'd0);
            end else begin
                logic [33:0] e;
                e = exp_q.pop_front();
                check(rd_word == e, "R2 word order and fields", 64'(rd_word), 64'(e));
            end
        end
        pend  = rd_go && rd_ready;
        rd_en = (rd_go && rd_ready) || force_rd;
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (6) @(negedge rd_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        @(negedge wr_clk);
        rd_wait(1);
        // R1 reset state
        check(!rd_valid && !rd_ready && !wr_full, "R1 flags clear", {rd_valid, rd_ready, wr_full}, 64'd0);
        check(!wr_err && !rd_err, "R1 errors clear", {wr_err, rd_err}, 64'd0);
        check(wr_level == 0 && rd_cells == 0, "R1 counts zero", {wr_level, rd_cells}, 64'd0);

        // partial cell stays locked (R5), occupancy visible (R6)
        @(negedge wr_clk);
        for (int i = 0; i < 10; i++) put_word(i == 0, 1'b0, 1'b1);
        rd_wait(20);
        check(rd_ready == 1'b0, "R5 partial cell not readable", 64'(rd_ready), 64'd0);
        check(rd_cells == 0, "R4 open cell not counted", 64'(rd_cells), 64'd0);
        check(wr_level == 10, "R6 level after 10 words", 64'(wr_level), 64'd10);

        // reaching MAX_CELL closes the cell (R4)
        @(negedge wr_clk);
        for (int i = 0; i < MAX_CELL - 10; i++) put_word(1'b0, 1'b0, 1'b1);
        rd_wait(20);
        check(rd_cells == 1, "R4 close by length", 64'(rd_cells), 64'd1);
        check(rd_ready == 1'b1, "R5 closed cell readable", 64'(rd_ready), 64'd1);

        // short idle cell closed by the next start word (R4)
        @(negedge wr_clk);
        put_cell(5, 1'b1);
        put_cell(3, 1'b0);
        rd_wait(20);
        check(rd_cells == 2, "R4 close by next start", 64'(rd_cells), 64'd2);

        // drain: reader must halt at the head of the open cell (R5)
        rd_go = 1'b1;
        for (int i = 0; i < 3000 && exp_q.size() > 3; i++) @(negedge rd_clk);
        rd_wait(20);
        check(exp_q.size() == 3, "R5 reader halts before open cell", 64'(exp_q.size()), 64'd3);
        check(rd_ready == 1'b0 && rd_cells == 0, "R5 gate at open cell", {rd_ready, rd_cells}, 64'd0);

        // stream cells while reading (R2, R4)
        @(negedge wr_clk);
        for (int c = 0; c < 8; c++) begin
            while (wr_level > DEPTH - MAX_CELL - 4) @(negedge wr_clk);
            put_cell(MAX_CELL, c[0]);
        end
        for (int i = 0; i < 5000 && exp_q.size() > 0; i++) @(negedge rd_clk);
        rd_wait(20);
        check(exp_q.size() == 0, "R2 stream fully delivered", 64'(exp_q.size()), 64'd0);
        check(wr_level == 0 && rd_cells == 0, "R6 empty after drain", {wr_level, rd_cells}, 64'd0);

        // fill to the top, then one write too many (R6, R7)
        rd_go = 1'b0;
        rd_wait(2);
        @(negedge wr_clk);
        for (int i = 0; i < DEPTH; i++) put_word(1'b0, 1'b0, 1'b1);
        check(wr_full == 1'b1 && wr_level == DEPTH, "R6 full at depth", {wr_full, wr_level}, {1'b1, 7'd64});
        check(wr_err == 1'b0, "R7 no error before overflow", 64'(wr_err), 64'd0);
        put_word(1'b0, 1'b1, 1'b0);
        check(wr_err == 1'b1, "R7 overflow flagged", 64'(wr_err), 64'd1);
        check(wr_level == DEPTH, "R7 dropped write not stored", 64'(wr_level), 64'd64);
        repeat (5) @(negedge wr_clk);
        check(wr_err == 1'b1, "R7 overflow sticky", 64'(wr_err), 64'd1);

        rd_go = 1'b1;
        for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge rd_clk);
        rd_wait(10);
        check(exp_q.size() == 0 && rd_ready == 1'b0, "R7 only stored words read", 64'(exp_q.size()), 64'd0);

        // read while not ready (R8)
        rd_go = 1'b0;
        @(posedge rd_clk);
        force_rd = 1'b1;
        @(posedge rd_clk);
        force_rd = 1'b0;
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R8 no data on underrun", 64'(rd_valid), 64'd0);
        check(rd_err == 1'b1, "R8 underrun flagged", 64'(rd_err), 64'd1);
        rd_wait(4);
        check(rd_err == 1'b1, "R8 underrun sticky", 64'(rd_err), 64'd1);

        // resets clear the flags (R9)
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        rd_wait(4);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        rd_wait(2);
        check(!wr_err && !rd_err, "R9 errors cleared", {wr_err, rd_err}, 64'd0);
        check(wr_level == 0 && !rd_valid && !rd_ready, "R9 pointers cleared", {wr_level, rd_valid, rd_ready}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule